// File: doc/BRIEF.md
# Sixteen-Bit Accumulator Processor Core

This block is a multicycle processor built around one 16-bit accumulator. It has a 12-bit program counter and a 12-bit memory address register, and it does its arithmetic in two's complement. The core fetches instruction words from a synchronous, word-addressed memory and executes them in a short sequence of states. The memory returns read data one cycle after the read request.

An instruction can reach its operand through a chain of indirect pointer words. Register-group instructions shift, rotate and test the accumulator. The core also has a small direct I/O port and a single interrupt level with a mask. It is meant to run display and terminal firmware that sits in an external memory.

Bit numbering in this brief follows the port vector. Bit 15 of the word is the leftmost bit, which is where the instruction format puts the indirect flag.

The state machine has nine states:
- FETCH reads the word at PC. It goes to IRQ instead when an interrupt is pending and the core is not masked; otherwise it goes to DECODE.
- DECODE latches the word. It goes to EXEC for a register-group word, to PTR_REQ for an indirect memory reference, and to OPERAND otherwise.
- PTR_REQ reads the pointer and then goes to PTR_TAKE.
- PTR_TAKE takes the pointer into the address register. It goes back to PTR_REQ if the pointer's bit 15 is set, and to OPERAND if it is clear.
- OPERAND either issues the operand read, which leads to MEMDONE, or finishes a jump, a store or a call.
- MEMDONE and EXEC complete the instruction. EXEC goes to HALT on a halt word.
- IRQ enters the service routine and returns to FETCH.
- HALT waits for run or step.

A completed instruction returns to FETCH. It goes to HALT instead when it was started by a single step.

Top module: `acc_core`

## Requirements
- R1: While rst_n is low, pc, acc and ovf read 0 (the PC reset value is parameter RESET_PC, default 0), halted is 0 and no memory write is issued.
- R2: Memory-reference words carry the indirect flag in bit 15, the opcode in bits 14:12 and the address A in bits 11:0. The opcodes used here are load 000, add 010, AND 100 and store 101. Add sets ovf on signed overflow. ovf keeps its value through every instruction except add, increment-and-skip, clear and interrupt return.
- R3: When bit 15 is set, the word at A is a pointer whose low 12 bits give the next address. If the pointer's own bit 15 is set, the core follows it again, and it does so for any number of levels.
- R4: Jump (001) loads PC with A. Call (011) writes PC+1 to location A, continues at A+1 and clears acc.
- R5: Increment-and-skip (110) writes M[A]+1 back to A and into acc, and sets ovf on signed overflow. It skips the next word when the result is zero.
- R6: Register-group words have bits 14:12 = 111, and bits 15:8 select the operation. 0x70 shifts acc left by n (bits 3:0) with zero fill, and 0xF0 rotates acc left by n.
- R7: Skips advance PC by 2 when their condition holds: 0x74 when acc is zero, 0xF4 when acc is nonzero, 0xF5 when acc bit (15-n) is set, and 0x75 when ovf is clear.
- R8: I/O words put the device in bits 7:4 and the function in bits 3:0 onto io_dev and io_func. 0x7C drives acc on io_dout with a one-cycle io_out_stb. 0x7D raises io_in_stb for one cycle and loads io_din into acc. 0x7E skips when io_sense[device] is 1.
- R9: A high irq sets a pending bit that stays set until the interrupt is taken. 0x78 masks and 0x7A unmasks. When the core is unmasked, the pending interrupt is taken before the next fetch: PC, acc and ovf are saved, the core is masked, and PC becomes IRQ_VEC (default 0x040). 0x7B restores the three saved values and unmasks.
- R10: 0x79 halts the core with PC past the halt word. Pulsing run resumes execution. Pulsing step executes one instruction and halts again.
- R11: A register-group word with any other bits 15:8 value does nothing except advance PC by 1.
- R12: 0x71 clears acc and ovf. 0x72 replaces acc with its two's-complement negation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read request; data is returned the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| io_dev | output | 4 | Device select |
| io_func | output | 4 | Function code |
| io_dout | output | 16 | Output data (accumulator) |
| io_din | input | 16 | Input data, valid while io_in_stb is high |
| io_out_stb | output | 1 | Output transfer strobe |
| io_in_stb | output | 1 | Input transfer strobe |
| io_sense | input | 16 | Per-device ready lines |
| irq | input | 1 | Interrupt request |
| run | input | 1 | Resume from halt |
| step | input | 1 | Execute one instruction from halt |
| halted | output | 1 | Core is in HALT |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| ovf | output | 1 | Overflow flag |

## Verification
Several rules are checked on every cycle:
- the pending bit holds until the interrupt is taken, and no interrupt is taken while masked;
- interrupt entry lands on the vector;
- a call leaves acc cleared;
- a halted core without run or step keeps its PC;
- ovf changes only in the completing states;
- a rotate keeps the accumulator's population count.

Whole instruction outcomes can only be shown by the bench's programs. These include the operand values, which words get skipped, the write-back of memory, chains of pointers, the strobe contents, the interrupt being deferred until unmask and then restored, and single-step behaviour.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DW   = 16;
    localparam int AW   = 12;
    localparam int SHW  = 4;
    localparam int DEVW = 4;
    localparam int NDEV = 1 << DEVW;

    typedef enum logic [4:0] {
        OP_LDA, OP_JMP, OP_ADD, OP_JSR, OP_AND, OP_STA, OP_IAS,
        OP_SAL, OP_RAL, OP_SAZ, OP_SNZ, OP_SBS, OP_SNO, OP_CLA, OP_NEG,
        OP_MASK, OP_UNMASK, OP_IRET, OP_HALT, OP_OUT, OP_IN, OP_SENSE, OP_NOP
    } op_e;

    typedef struct packed {
        op_e             op;
        logic            mem_ref;
        logic            ind;
        logic [AW-1:0]   addr;
        logic [SHW-1:0]  nf;
        logic [DEVW-1:0] dev;
        logic [3:0]      func;
    } dec_t;

    typedef enum logic [2:0] {
        ALU_PASS, ALU_ADD, ALU_AND, ALU_INC, ALU_SHL, ALU_ROL, ALU_NEG
    } alu_e;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_PTR_REQ, S_PTR_TAKE, S_OPERAND,
        S_MEMDONE, S_EXEC, S_IRQ, S_HALT
    } state_e;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [DW-1:0] ir,
    output dec_t          d
);
    always_comb begin
        d.mem_ref = (ir[DW-2:DW-4] != 3'b111);
        d.ind     = ir[DW-1] & d.mem_ref;
        d.addr    = ir[AW-1:0];
        d.nf      = ir[SHW-1:0];
        d.dev     = ir[7:4];
        d.func    = ir[3:0];
        d.op      = OP_NOP;
        unique case (ir[DW-2:DW-4])
            3'b000: d.op = OP_LDA;
            3'b001: d.op = OP_JMP;
            3'b010: d.op = OP_ADD;
            3'b011: d.op = OP_JSR;
            3'b100: d.op = OP_AND;
            3'b101: d.op = OP_STA;
            3'b110: d.op = OP_IAS;
            default: begin
                case (ir[DW-1:8])
                    8'h70:   d.op = OP_SAL;
                    8'hF0:   d.op = OP_RAL;
                    8'h74:   d.op = OP_SAZ;
                    8'hF4:   d.op = OP_SNZ;
                    8'hF5:   d.op = OP_SBS;
                    8'h75:   d.op = OP_SNO;
                    8'h71:   d.op = OP_CLA;
                    8'h72:   d.op = OP_NEG;
                    8'h78:   d.op = OP_MASK;
                    8'h79:   d.op = OP_HALT;
                    8'h7A:   d.op = OP_UNMASK;
                    8'h7B:   d.op = OP_IRET;
                    8'h7C:   d.op = OP_OUT;
                    8'h7D:   d.op = OP_IN;
                    8'h7E:   d.op = OP_SENSE;
                    default: d.op = OP_NOP;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  alu_e           sel,
    input  logic [SHW-1:0] amt,
    output logic [DW-1:0]  y,
    output logic           v
);
    localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] MAXP = {1'b0, {(DW-1){1'b1}}};

    logic [2*DW-1:0] dbl;
    logic [DW-1:0]   sum;

    always_comb begin
        dbl = {a, a} << amt;
        sum = a + b;
        y   = a;
        v   = 1'b0;
        unique case (sel)
            ALU_ADD: begin
                y = sum;
                v = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
            end
            ALU_AND: y = a & b;
            ALU_INC: begin
                y = b + ONE;
                v = (b == MAXP);
            end
            ALU_SHL: y = a << amt;
            ALU_ROL: y = dbl[2*DW-1:DW];
            ALU_NEG: y = (~a) + ONE;
            default: y = a;
        endcase
    end

    always_comb begin
        if (sel == ALU_ROL) begin
            AST_ROL_POPCOUNT: assert ($countones(y) == $countones(a)); // R6
        end
    end
endmodule

// File: rtl/acc_irq.sv
module acc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic mask_set,
    input  logic mask_clr,
    input  logic take,
    output logic pend,
    output logic masked
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            masked <= 1'b0;
        end else begin
            pend <= (pend & ~take) | irq;
            if (mask_set)
                masked <= 1'b1;
            else if (mask_clr)
                masked <= 1'b0;
        end
    end

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !take) |=> pend); // R9
    AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> masked); // R9
    AST_NO_TAKE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        masked |-> !take); // R9
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = '0,
    parameter logic [AW-1:0] IRQ_VEC  = 12'h040
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DEVW-1:0] io_dev,
    output logic [3:0]      io_func,
    output logic [DW-1:0]   io_dout,
    input  logic [DW-1:0]   io_din,
    output logic            io_out_stb,
    output logic            io_in_stb,
    input  logic [NDEV-1:0] io_sense,
    input  logic            irq,
    input  logic            run,
    input  logic            step,
    output logic            halted,
    output logic [DW-1:0]   acc,
    output logic [AW-1:0]   pc,
    output logic            ovf
);
    localparam logic [AW-1:0] PC1 = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] PC2 = {{(AW-2){1'b0}}, 2'b10};

    state_e        state_q, state_d, done_tgt;
    logic [AW-1:0] pc_q, ma_q, sh_pc;
    logic [DW-1:0] ac_q, ir_q, sh_ac, ir_src;
    logic          ov_q, sh_ov, single_q;
    dec_t          dec;
    alu_e          alu_sel;
    logic [DW-1:0] alu_y;
    logic          alu_v;
    logic          pend, masked, irq_go, take, mask_set, mask_clr, skip;

    assign ir_src = (state_q == S_DECODE) ? mem_rdata : ir_q;

    acc_decode u_dec (.ir(ir_src), .d(dec));

    always_comb begin
        unique case (dec.op)
            OP_ADD:  alu_sel = ALU_ADD;
            OP_AND:  alu_sel = ALU_AND;
            OP_IAS:  alu_sel = ALU_INC;
            OP_SAL:  alu_sel = ALU_SHL;
            OP_RAL:  alu_sel = ALU_ROL;
            OP_NEG:  alu_sel = ALU_NEG;
            default: alu_sel = ALU_PASS;
        endcase
    end

    acc_alu u_alu (
        .a(ac_q), .b(mem_rdata), .sel(alu_sel), .amt(dec.nf),
        .y(alu_y), .v(alu_v)
    );

    assign take     = (state_q == S_IRQ);
    assign mask_set = take || (state_q == S_EXEC && dec.op == OP_MASK);
    assign mask_clr = (state_q == S_EXEC) && (dec.op == OP_UNMASK || dec.op == OP_IRET);

    acc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mask_set(mask_set),
        .mask_clr(mask_clr), .take(take), .pend(pend), .masked(masked)
    );

    assign irq_go   = pend & ~masked;
    assign done_tgt = single_q ? S_HALT : S_FETCH;

    always_comb begin
        unique case (dec.op)
            OP_SAZ:   skip = (ac_q == '0);
            OP_SNZ:   skip = (ac_q != '0);
            OP_SBS:   skip = ac_q[4'd15 - dec.nf];
            OP_SNO:   skip = !ov_q;
            OP_SENSE: skip = io_sense[dec.dev];
            default:  skip = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH:    state_d = irq_go ? S_IRQ : S_DECODE;
            S_DECODE:   state_d = !dec.mem_ref ? S_EXEC : (dec.ind ? S_PTR_REQ : S_OPERAND);
            S_PTR_REQ:  state_d = S_PTR_TAKE;
            S_PTR_TAKE: state_d = mem_rdata[DW-1] ? S_PTR_REQ : S_OPERAND;
            S_OPERAND: begin
                if (dec.op == OP_JMP || dec.op == OP_STA || dec.op == OP_JSR)
                    state_d = done_tgt;
                else
                    state_d = S_MEMDONE;
            end
            S_MEMDONE:  state_d = done_tgt;
            S_EXEC:     state_d = (dec.op == OP_HALT) ? S_HALT : done_tgt;
            S_IRQ:      state_d = S_FETCH;
            S_HALT:     state_d = (run || step) ? S_FETCH : S_HALT;
            default:    state_d = S_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_FETCH;
        else
            state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_PC;
            ac_q     <= '0;
            ov_q     <= 1'b0;
            ir_q     <= '0;
            ma_q     <= '0;
            sh_pc    <= '0;
            sh_ac    <= '0;
            sh_ov    <= 1'b0;
            single_q <= 1'b0;
        end else begin
            if (state_q == S_HALT) begin
                if (step)
                    single_q <= 1'b1;
                else if (run)
                    single_q <= 1'b0;
            end else if (state_d == S_HALT) begin
                single_q <= 1'b0;
            end
            unique case (state_q)
                S_DECODE: begin
                    ir_q <= mem_rdata;
                    ma_q <= mem_rdata[AW-1:0];
                end
                S_PTR_TAKE: ma_q <= mem_rdata[AW-1:0];
                S_OPERAND: begin
                    if (dec.op == OP_JMP) begin
                        pc_q <= ma_q;
                    end else if (dec.op == OP_STA) begin
                        pc_q <= pc_q + PC1;
                    end else if (dec.op == OP_JSR) begin
                        pc_q <= ma_q + PC1;
                        ac_q <= '0;
                    end
                end
                S_MEMDONE: begin
                    pc_q <= pc_q + PC1;
                    unique case (dec.op)
                        OP_LDA: ac_q <= mem_rdata;
                        OP_AND: ac_q <= alu_y;
                        OP_ADD: begin
                            ac_q <= alu_y;
                            ov_q <= alu_v;
                        end
                        OP_IAS: begin
                            ac_q <= alu_y;
                            ov_q <= alu_v;
                            if (alu_y == '0)
                                pc_q <= pc_q + PC2;
                        end
                        default: ;
                    endcase
                end
                S_EXEC: begin
                    pc_q <= skip ? pc_q + PC2 : pc_q + PC1;
                    unique case (dec.op)
                        OP_SAL, OP_RAL, OP_NEG: ac_q <= alu_y;
                        OP_CLA: begin
                            ac_q <= '0;
                            ov_q <= 1'b0;
                        end
                        OP_IN: ac_q <= io_din;
                        OP_IRET: begin
                            pc_q <= sh_pc;
                            ac_q <= sh_ac;
                            ov_q <= sh_ov;
                        end
                        default: ;
                    endcase
                end
                S_IRQ: begin
                    sh_pc <= pc_q;
                    sh_ac <= ac_q;
                    sh_ov <= ov_q;
                    pc_q  <= IRQ_VEC;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr   = pc_q;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        mem_wdata  = ac_q;
        io_out_stb = 1'b0;
        io_in_stb  = 1'b0;
        unique case (state_q)
            S_FETCH:   mem_rd = !irq_go;
            S_PTR_REQ: begin
                mem_addr = ma_q;
                mem_rd   = 1'b1;
            end
            S_OPERAND: begin
                mem_addr = ma_q;
                if (dec.op == OP_STA) begin
                    mem_wr = 1'b1;
                end else if (dec.op == OP_JSR) begin
                    mem_wr    = 1'b1;
                    mem_wdata = {{(DW-AW){1'b0}}, pc_q + PC1};
                end else if (dec.op != OP_JMP) begin
                    mem_rd = 1'b1;
                end
            end
            S_MEMDONE: begin
                mem_addr = ma_q;
                if (dec.op == OP_IAS) begin
                    mem_wr    = 1'b1;
                    mem_wdata = alu_y;
                end
            end
            S_EXEC: begin
                io_out_stb = (dec.op == OP_OUT);
                io_in_stb  = (dec.op == OP_IN);
            end
            default: ;
        endcase
    end

    assign io_dev  = dec.dev;
    assign io_func = dec.func;
    assign io_dout = ac_q;
    assign halted  = (state_q == S_HALT);
    assign acc     = ac_q;
    assign pc      = pc_q;
    assign ovf     = ov_q;

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IRQ) |=> (pc_q == IRQ_VEC)); // R9
    AST_CALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OPERAND && dec.op == OP_JSR) |=> (ac_q == '0)); // R4
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT && !run && !step) |=> (state_q == S_HALT && $stable(pc_q))); // R10
    AST_OVF_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ov_q) |-> ($past(state_q) == S_MEMDONE || $past(state_q) == S_EXEC)); // R2
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_out_stb && io_in_stb)); // R8
    AST_RESET_NO_WRITE: assert property (@(posedge clk)
        !rst_n |-> !mem_wr); // R1
endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [3:0]  io_dev, io_func;
    logic [15:0] io_dout, io_din;
    logic        io_out_stb, io_in_stb;
    logic [15:0] io_sense = 16'h0200;
    logic        irq = 1'b0, run = 1'b0, step = 1'b0;
    logic        halted, ovf;
    logic [15:0] acc;
    logic [11:0] pc;

    logic [15:0] mem [0:1023];
    int n_chk = 0;
    int n_err = 0;
    int out_cnt = 0, in_cnt = 0;
    logic [3:0]  out_dev, out_func;
    logic [15:0] out_data;
    logic [69:0] v;

    always #4 clk = ~clk;

    acc_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_dev(io_dev), .io_func(io_func), .io_dout(io_dout), .io_din(io_din),
        .io_out_stb(io_out_stb), .io_in_stb(io_in_stb), .io_sense(io_sense),
        .irq(irq), .run(run), .step(step), .halted(halted), .acc(acc),
        .pc(pc), .ovf(ovf)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (io_out_stb) begin
            out_cnt  <= out_cnt + 1;
            out_dev  <= io_dev;
            out_func <= io_func;
            out_data <= io_dout;
        end
        if (io_in_stb) in_cnt <= in_cnt + 1;
    end

    assign io_din = (io_in_stb && io_dev == 4'd6) ? 16'h1357 : 16'h0000;

    // ins, ac0, opnd, expected acc, expected ovf, store happens, requirement
    localparam logic [69:0] VECS [0:23] = '{
        {16'h0101, 16'h1111, 16'hBEEF, 16'hBEEF, 1'b0, 1'b1, 4'd2},  // R2 load
        {16'h2101, 16'h0005, 16'h0007, 16'h000C, 1'b0, 1'b1, 4'd2},  // R2 add
        {16'h2101, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 1'b1, 4'd2},  // R2 add overflow
        {16'h2101, 16'h8000, 16'hFFFF, 16'h7FFF, 1'b1, 1'b1, 4'd2},  // R2 negative overflow
        {16'h4101, 16'hF0F0, 16'h3CC3, 16'h30C0, 1'b0, 1'b1, 4'd2},  // R2 and
        {16'h6101, 16'h0AAA, 16'h0004, 16'h0005, 1'b0, 1'b1, 4'd5},  // R5 no skip
        {16'h6101, 16'h0AAA, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 wraps, skip
        {16'h6101, 16'h0000, 16'h7FFF, 16'h8000, 1'b1, 1'b1, 4'd5},  // R5 overflow
        {16'h7004, 16'h1234, 16'h0000, 16'h2340, 1'b0, 1'b1, 4'd6},  // R6 shift
        {16'hF004, 16'h1234, 16'h0000, 16'h2341, 1'b0, 1'b1, 4'd6},  // R6 rotate
        {16'hF00F, 16'h8001, 16'h0000, 16'hC000, 1'b0, 1'b1, 4'd6},  // R6 rotate 15
        {16'h700F, 16'h0003, 16'h0000, 16'h8000, 1'b0, 1'b1, 4'd6},  // R6 shift 15
        {16'h7400, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 zero skip
        {16'h7400, 16'h0003, 16'h0000, 16'h0003, 1'b0, 1'b1, 4'd7},  // R7 zero no skip
        {16'hF400, 16'h0003, 16'h0000, 16'h0003, 1'b0, 1'b0, 4'd7},  // R7 nonzero skip
        {16'hF400, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 4'd7},  // R7 nonzero no skip
        {16'hF500, 16'h8000, 16'h0000, 16'h8000, 1'b0, 1'b0, 4'd7},  // R7 bit 15
        {16'hF50F, 16'h8000, 16'h0000, 16'h8000, 1'b0, 1'b1, 4'd7},  // R7 bit 0 clear
        {16'hF50F, 16'h0001, 16'h0000, 16'h0001, 1'b0, 1'b0, 4'd7},  // R7 bit 0 set
        {16'h7100, 16'h1234, 16'h0000, 16'h0000, 1'b0, 1'b1, 4'd12}, // R12 clear
        {16'h7200, 16'h0001, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 4'd12}, // R12 negate
        {16'h7200, 16'h8000, 16'h0000, 16'h8000, 1'b0, 1'b1, 4'd12}, // R12 negate min
        {16'h7F00, 16'h55AA, 16'h0000, 16'h55AA, 1'b0, 1'b1, 4'd11}, // R11 undefined
        {16'hF100, 16'h55AA, 16'h0000, 16'h55AA, 1'b0, 1'b1, 4'd11}  // R11 undefined
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fill();
        for (int i = 0; i < 1024; i++) mem[i] = 16'h7900;
        mem[10'h102] = 16'hDEAD;
        mem[10'h103] = 16'hDEAD;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fill();
    endtask

    task automatic release_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string tag);
        int k = 0;
        @(negedge clk);
        while (!halted && k < 4000) begin
            @(negedge clk);
            k++;
        end
        chk(tag, {31'b0, halted}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1 reset state
        enter_reset();
        @(negedge clk);
        chk("R1 pc", {20'b0, pc}, 32'h0);
        chk("R1 acc", {16'b0, acc}, 32'h0);
        chk("R1 ovf", {31'b0, ovf}, 32'h0);
        chk("R1 halted", {31'b0, halted}, 32'h0);
        chk("R1 mem_wr", {31'b0, mem_wr}, 32'h0);

        // table walk
        for (int i = 0; i < 24; i++) begin
            v = VECS[i];
            enter_reset();
            mem[0] = 16'h0100;
            mem[1] = v[69:54];
            mem[2] = 16'h5102;
            mem[3] = 16'h7900;
            mem[10'h100] = v[53:38];
            mem[10'h101] = v[37:22];
            release_reset();
            wait_halt($sformatf("R%0d row %0d halt", v[3:0], i));
            chk($sformatf("R%0d row %0d acc", v[3:0], i), {16'b0, acc}, {16'b0, v[21:6]});
            chk($sformatf("R%0d row %0d ovf", v[3:0], i), {31'b0, ovf}, {31'b0, v[5]});
            chk($sformatf("R%0d row %0d pc", v[3:0], i), {20'b0, pc}, 32'h4);
            chk($sformatf("R%0d row %0d stored", v[3:0], i), {16'b0, mem[10'h102]},
                v[4] ? {16'b0, v[21:6]} : 32'hDEAD);
            if (v[68:66] == 3'b110)
                chk($sformatf("R5 row %0d writeback", i), {16'b0, mem[10'h101]}, {16'b0, v[21:6]});
        end

        // R3 multi-level indirect load and indirect store
        enter_reset();
        mem[0] = 16'h8100;
        mem[1] = 16'hD104;
        mem[10'h100] = 16'h8101;
        mem[10'h101] = 16'h0103;
        mem[10'h103] = 16'h4242;
        mem[10'h104] = 16'h0105;
        release_reset();
        wait_halt("R3 halt");
        chk("R3 indirect load", {16'b0, acc}, 32'h4242);
        chk("R3 indirect store", {16'b0, mem[10'h105]}, 32'h4242);
        chk("R3 pc", {20'b0, pc}, 32'h3);

        // R4 call then jump
        enter_reset();
        mem[0] = 16'h0100;
        mem[1] = 16'h3020;
        mem[10'h020] = 16'h0000;
        mem[10'h021] = 16'h1030;
        mem[10'h100] = 16'h0077;
        release_reset();
        wait_halt("R4 halt");
        chk("R4 return address", {16'b0, mem[10'h020]}, 32'h0002);
        chk("R4 acc cleared", {16'b0, acc}, 32'h0);
        chk("R4 pc after jump", {20'b0, pc}, 32'h031);

        // R2 overflow held, R7 no-overflow skip, R12 clear resets ovf
        enter_reset();
        mem[0] = 16'h0100; mem[1] = 16'h2101; mem[2] = 16'h0100; mem[3] = 16'h4100;
        mem[4] = 16'h7500; mem[5] = 16'h5102; mem[6] = 16'h7100; mem[7] = 16'h7500;
        mem[8] = 16'h5103;
        mem[10'h100] = 16'h7FFF;
        mem[10'h101] = 16'h0001;
        release_reset();
        wait_halt("R2 halt");
        chk("R2 ovf held through load and AND", {16'b0, mem[10'h102]}, 32'h7FFF);
        chk("R7 skip when ovf clear", {16'b0, mem[10'h103]}, 32'hDEAD);
        chk("R12 clear drops ovf", {31'b0, ovf}, 32'h0);
        chk("R7 pc", {20'b0, pc}, 32'h00A);

        // R8 direct I/O
        enter_reset();
        mem[0] = 16'h0100; mem[1] = 16'h7C35; mem[2] = 16'h7D62; mem[3] = 16'h5102;
        mem[4] = 16'h7E90; mem[5] = 16'h5103;
        mem[10'h100] = 16'hA5A5;
        out_cnt = 0;
        in_cnt = 0;
        release_reset();
        wait_halt("R8 halt");
        chk("R8 out pulses", out_cnt, 32'd1);
        chk("R8 out device", {28'b0, out_dev}, 32'h3);
        chk("R8 out function", {28'b0, out_func}, 32'h5);
        chk("R8 out data", {16'b0, out_data}, 32'hA5A5);
        chk("R8 in pulses", in_cnt, 32'd1);
        chk("R8 input word", {16'b0, mem[10'h102]}, 32'h1357);
        chk("R8 sense skip", {16'b0, mem[10'h103]}, 32'hDEAD);

        // R9 interrupt held while masked, serviced after unmask, state restored
        enter_reset();
        mem[0] = 16'h7800; mem[1] = 16'h0100; mem[2] = 16'h7A00; mem[3] = 16'h5102;
        mem[10'h040] = 16'h0104; mem[10'h041] = 16'h5103; mem[10'h042] = 16'h7B00;
        mem[10'h100] = 16'h0011;
        mem[10'h104] = 16'h0999;
        release_reset();
        begin
            int k = 0;
            while (pc != 12'h001 && k < 100) begin
                @(negedge clk);
                k++;
            end
        end
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        wait_halt("R9 halt");
        chk("R9 service routine ran", {16'b0, mem[10'h103]}, 32'h0999);
        chk("R9 acc restored", {16'b0, mem[10'h102]}, 32'h0011);
        chk("R9 pc restored", {20'b0, pc}, 32'h005);

        // R10 halt, step, run
        enter_reset();
        mem[0] = 16'h7900; mem[1] = 16'h0100; mem[2] = 16'h2100; mem[3] = 16'h2100;
        mem[4] = 16'h7900;
        mem[10'h100] = 16'h0001;
        release_reset();
        wait_halt("R10 first halt");
        chk("R10 pc past halt", {20'b0, pc}, 32'h1);
        repeat (5) @(negedge clk);
        chk("R10 stays halted", {31'b0, halted}, 32'h1);
        chk("R10 pc held", {20'b0, pc}, 32'h1);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        wait_halt("R10 step halt");
        chk("R10 one step pc", {20'b0, pc}, 32'h2);
        chk("R10 one step acc", {16'b0, acc}, 32'h1);
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        wait_halt("R10 run halt");
        chk("R10 run pc", {20'b0, pc}, 32'h5);
        chk("R10 run acc", {16'b0, acc}, 32'h3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule